// File: doc/BRIEF.md
# Reference-Locked Fine-Tick Frequency Multiplier

This block synthesizes an output bit whose frequency is a programmable multiple of a slow external reference pulse. Everything runs on one fast system clock. The reference is brought into the clock domain and its rising edges are found. A counter then measures how many system cycles lie between consecutive edges. The cycle that captures a measurement also counts as the first cycle of the next one, so no time is lost between measurements.

The latest measured period drives a fractional tick generator. It emits single-cycle enable pulses at 2^FINE_LOG2 times the reference rate and carries the remainder from one tick to the next. Each tick adds a step constant to a phase register, and the top bit of that register is the output. The output frequency is therefore reference × step × 2^FINE_LOG2 / 2^PHASE_W. Output edges fall only on system clock edges, so the output carries up to one system period of timing jitter.

The tick is a clock enable, not a derived clock. The block also reports the measured period, a strobe for each new measurement, a lock-valid flag and a sticky flag for a period that is too short.

Top module: `refclk_mult`

## Requirements
- R1: After a synchronous reset, synth_out, period_meas, meas_strobe, period_valid and range_err are all 0.
- R2: period_meas equals the number of system cycles between two consecutive reference rising edges, counting the capturing cycle as the first cycle of the next period. It updates together with a one-cycle meas_strobe, which fires once per edge after the first, and is stable at all other times.
- R3: The first reference rising edge after reset only arms the measurement. period_valid rises with the first strobe, and no fine tick (no phase change) occurs before that.
- R4: While valid and in range, the tick generator emits on average exactly 2^FINE_LOG2 ticks per measured period. The remainder is carried forward, so the count does not drift even when the period is not a multiple of 2^FINE_LOG2.
- R5: Each fine tick adds step_k to a PHASE_W-bit phase register, modulo 2^PHASE_W. synth_out is its most significant bit, and the phase does not change between ticks. With step_k = 0 the output stays constant.
- R6: The output frequency is the reference frequency × step_k × 2^FINE_LOG2 / 2^PHASE_W. With the default parameters and step_k = 16, there is one output rising edge per two reference periods.
- R7: When a valid measured period is below 2^FINE_LOG2 cycles, range_err is set and stays set until reset, and no ticks are issued while the current period is short. Ticks resume once a long-enough period is measured.
- R8: The reference passes through a SYNC_STAGES-flop synchronizer. Only a low-to-high transition creates an edge, and a reference held high creates no further measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Asynchronous reference pulse |
| step_k | input | PHASE_W | Phase increment applied per fine tick |
| synth_out | output | 1 | Synthesized output (phase MSB) |
| period_meas | output | PERIOD_W | Latest measured reference period in system cycles |
| meas_strobe | output | 1 | One-cycle pulse when period_meas is updated |
| period_valid | output | 1 | A full period has been measured |
| range_err | output | 1 | Sticky: a measured period was below 2^FINE_LOG2 |

## Verification
The embedded assertions check several properties on every cycle:
- the measured period changes only on a strobe;
- a strobe and a tick never occur before the valid flag;
- the phase holds between ticks;
- the range flag never clears once set;
- the edge pulse never lasts two cycles.

Only the bench scenarios can show the following:
- the measured value is exact, with no dead cycle, across period changes;
- the long-run tick rate, and so the output edge count over many periods, holds both for periods that are multiples of the fine ratio and for periods that are not;
- the output frequency follows the step constant;
- a reference held high is not re-measured.

// File: rtl/rlm_pkg.sv
package rlm_pkg;
   // operating mode of the fine tick generator
   typedef enum logic [1:0] {
      TG_IDLE = 2'd0,   // no full period measured yet
      TG_RUN  = 2'd1,   // ticking from the measured period
      TG_HOLD = 2'd2    // measured period shorter than the fine ratio
   } tg_mode_e;
endpackage

// File: rtl/rlm_edge_sync.sv
module rlm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_i,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   logic [STAGES:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rlm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-1:0], raw_i};
   end

   assign rise_o = chain_q[LAST] & ~chain_q[STAGES];

   // a detected edge never lasts two cycles
   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      rise_o |=> !rise_o);
endmodule

// File: rtl/rlm_period_meter.sv
module rlm_period_meter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         rise_i,
   output logic [W-1:0] period_o,
   output logic         strobe_o,
   output logic         valid_o
);
   localparam logic [W-1:0] CNT_MAX = '1;

   logic [W-1:0] cnt_q;
   logic         armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         period_o <= '0;
         strobe_o <= 1'b0;
         valid_o  <= 1'b0;
      end else begin
         strobe_o <= 1'b0;
         if (rise_i) begin
            // this cycle already belongs to the new period
            cnt_q   <= W'(1);
            armed_q <= 1'b1;
            if (armed_q) begin
               period_o <= cnt_q;
               strobe_o <= 1'b1;
               valid_o  <= 1'b1;
            end
         end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + W'(1);
         end
      end
   end

   assert_period_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(period_o) |-> strobe_o);

   assert_strobe_after_arm_R3: assert property (@(posedge clk) disable iff (rst)
      strobe_o |-> valid_o);
endmodule

// File: rtl/rlm_tick_gen.sv
module rlm_tick_gen
   import rlm_pkg::*;
#(
   parameter int W = 16,
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] period_i,
   input  logic         valid_i,
   output logic         tick_o,
   output logic         range_err_o
);
   localparam int            AW   = W + 1;
   localparam logic [AW-1:0] STEP = AW'(1) << N;

   logic [AW-1:0] acc_q;
   logic [AW-1:0] per_ext;
   logic [AW-1:0] sum;
   logic [AW-1:0] wrap;
   logic          short_per;
   tg_mode_e      mode;

   assign per_ext   = {1'b0, period_i};
   assign short_per = per_ext < STEP;
   assign sum       = acc_q + STEP;
   assign wrap      = sum - per_ext;

   always_comb begin
      if (!valid_i)      mode = TG_IDLE;
      else if (short_per) mode = TG_HOLD;
      else               mode = TG_RUN;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q       <= '0;
         tick_o      <= 1'b0;
         range_err_o <= 1'b0;
      end else begin
         tick_o <= 1'b0;
         if (valid_i && short_per) range_err_o <= 1'b1;
         case (mode)
            TG_RUN: begin
               if (sum >= per_ext) begin
                  tick_o <= 1'b1;
                  // a remainder still above a shrunken period restarts the phase
                  acc_q  <= (wrap >= per_ext) ? '0 : wrap;
               end else begin
                  acc_q <= sum;
               end
            end
            default: acc_q <= '0;
         endcase
      end
   end

   assert_tick_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
      tick_o |-> valid_i);

   assert_range_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      $past(range_err_o) |-> range_err_o);
endmodule

// File: rtl/rlm_phase_acc.sv
module rlm_phase_acc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         tick_i,
   input  logic [W-1:0] step_i,
   output logic         msb_o
);
   logic [W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst)         phase_q <= '0;
      else if (tick_i) phase_q <= phase_q + step_i;
   end

   assign msb_o = phase_q[W-1];

   assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !tick_i |=> $stable(phase_q));
endmodule

// File: rtl/refclk_mult.sv
module refclk_mult #(
   parameter int PERIOD_W    = 16,
   parameter int FINE_LOG2   = 3,
   parameter int PHASE_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ref_in,
   input  logic [PHASE_W-1:0]  step_k,
   output logic                synth_out,
   output logic [PERIOD_W-1:0] period_meas,
   output logic                meas_strobe,
   output logic                period_valid,
   output logic                range_err
);
   generate
      if (FINE_LOG2 < 0 || FINE_LOG2 >= PERIOD_W - 1) begin : g_bad_fine
         $error("refclk_mult: FINE_LOG2 must lie in 0..PERIOD_W-2");
      end
      if (PHASE_W < 2) begin : g_bad_phase
         $error("refclk_mult: PHASE_W must be at least 2");
      end
   endgenerate

   logic ref_rise;
   logic fine_tick;

   rlm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (ref_in),
      .rise_o (ref_rise)
   );

   rlm_period_meter #(.W(PERIOD_W)) u_meter (
      .clk      (clk),
      .rst      (rst),
      .rise_i   (ref_rise),
      .period_o (period_meas),
      .strobe_o (meas_strobe),
      .valid_o  (period_valid)
   );

   rlm_tick_gen #(.W(PERIOD_W), .N(FINE_LOG2)) u_tick (
      .clk         (clk),
      .rst         (rst),
      .period_i    (period_meas),
      .valid_i     (period_valid),
      .tick_o      (fine_tick),
      .range_err_o (range_err)
   );

   rlm_phase_acc #(.W(PHASE_W)) u_phase (
      .clk    (clk),
      .rst    (rst),
      .tick_i (fine_tick),
      .step_i (step_k),
      .msb_o  (synth_out)
   );
endmodule

// File: tb/tb_refclk_mult.sv
module tb_refclk_mult;
   localparam int PERIOD_W = 16;
   localparam int PHASE_W  = 8;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic                ref_in = 1'b0;
   logic [PHASE_W-1:0]  step_k = '0;
   logic                synth_out;
   logic [PERIOD_W-1:0] period_meas;
   logic                meas_strobe;
   logic                period_valid;
   logic                range_err;

   refclk_mult #(.PERIOD_W(PERIOD_W), .FINE_LOG2(3), .PHASE_W(PHASE_W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst(rst), .ref_in(ref_in), .step_k(step_k),
      .synth_out(synth_out), .period_meas(period_meas), .meas_strobe(meas_strobe),
      .period_valid(period_valid), .range_err(range_err)
   );

   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rise_cnt = 0;
   int last_rise = 0;
   bit have_prev = 1'b0;
   bit done = 1'b0;
   logic prev_out = 1'b0;
   int exp_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // driver: a rising edge of the reference pushes the expected spacing
   task automatic ref_rise_now();
      ref_in = 1'b1;
      if (have_prev) exp_q.push_back(cyc - last_rise);
      last_rise = cyc;
      have_prev = 1'b1;
   endtask

   task automatic run_periods(input int p, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ref_rise_now();
         repeat (p / 2) @(negedge clk);
         ref_in = 1'b0;
         repeat (p - p / 2 - 1) @(negedge clk);
      end
   endtask

   // monitor: scoreboard for period measurements and output edge counting
   always @(negedge clk) begin
      if (!rst) begin
         if (meas_strobe) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected strobe", int'(period_meas), -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(int'(period_meas) == e, "R2 measured period", int'(period_meas), e);
            end
         end
         if (synth_out && !prev_out) rise_cnt++;
         prev_out <= synth_out;
      end else begin
         prev_out <= 1'b0;
      end
   end

   initial begin
      logic snap;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(synth_out == 1'b0, "R1 synth_out", synth_out, 0);
      chk(period_meas == '0, "R1 period_meas", int'(period_meas), 0);
      chk(meas_strobe == 1'b0, "R1 meas_strobe", meas_strobe, 0);
      chk(period_valid == 1'b0, "R1 period_valid", period_valid, 0);
      chk(range_err == 1'b0, "R1 range_err", range_err, 0);

      // R3/R8: first edge only arms; a held-high reference is not re-measured
      step_k = 8'd128;
      ref_rise_now();
      repeat (300) @(negedge clk);
      chk(period_valid == 1'b0, "R3 valid after one edge", period_valid, 0);
      chk(synth_out == 1'b0, "R3 no ticks before valid", synth_out, 0);
      chk(exp_q.size() == 0, "R8 no strobe while held high", exp_q.size(), 0);
      ref_in = 1'b0;
      repeat (10) @(negedge clk);
      run_periods(40, 4);
      chk(period_valid == 1'b1, "R3 valid after second edge", period_valid, 1);

      // R6: step 16 -> one output rising edge per two reference periods
      step_k = 8'd16;
      run_periods(40, 2);
      rise_cnt = 0;
      run_periods(40, 40);
      chk(rise_cnt >= 19 && rise_cnt <= 21, "R6 rate step16 P40", rise_cnt, 20);

      // R4: period not a multiple of the fine ratio, remainder carried
      step_k = 8'd32;
      run_periods(37, 2);
      rise_cnt = 0;
      run_periods(37, 40);
      chk(rise_cnt >= 39 && rise_cnt <= 41, "R4 rate step32 P37", rise_cnt, 40);

      // R5: zero step freezes the output
      step_k = 8'd0;
      run_periods(37, 2);
      snap = synth_out;
      rise_cnt = 0;
      run_periods(37, 10);
      chk(synth_out == snap, "R5 output frozen", synth_out, snap);
      chk(rise_cnt == 0, "R5 no edges with zero step", rise_cnt, 0);

      // R2: period change tracked exactly
      run_periods(55, 5);
      chk(int'(period_meas) == 55, "R2 new period", int'(period_meas), 55);

      // R7: short period raises sticky flag and stops ticks
      step_k = 8'd32;
      run_periods(6, 3);
      chk(range_err == 1'b1, "R7 range_err set", range_err, 1);
      rise_cnt = 0;
      snap = synth_out;
      run_periods(6, 6);
      chk(rise_cnt == 0 && synth_out == snap, "R7 no ticks while short", rise_cnt, 0);
      run_periods(40, 20);
      chk(range_err == 1'b1, "R7 range_err sticky", range_err, 1);
      chk(rise_cnt > 10, "R7 ticks resume", rise_cnt, 18);

      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all measurements seen", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule